// File: doc/BRIEF.md
# Double-Key Register Write Guard

The block sits on a single-cycle register write bus in front of a group of critical control registers (memory-controller chip-select and area settings, address-translation bank settings, system and clock-gear control, PLL control). Each bus write is either forwarded to the register bank in the same cycle or suppressed. Writes are suppressed when the guard is armed and the address falls inside a parameterised set of protected address ranges.

The guard state can only be changed by a deliberate sequence. Software first writes an opening key pair and then a closing key pair to two key registers. It then writes the desired value into bit 0 of a status register. Each change needs a fresh sequence. Every suppressed write produces a one-cycle violation interrupt pulse and advances a saturating counter of blocked writes. The guard state can be read back through the status register's read path.

Top module: `write_guard`

## Requirements
- R1: After reset the guard is off, `violIrq` is low and `blockCount` is 0.
- R2: The opening key is two writes: 8'h5A to key register A (address 8'hF1), then 8'hA5 to key register B (address 8'hF2).
- R3: After the opening key, the closing key is 8'hA5 to key register A, then 8'h5A to key register B. Once both are written, the next write to the status register (address 8'hF0) loads bit 0 of the write data into the guard state. The new state is visible on `protectOn` from the following cycle.
- R4: Any of the following returns the key sequence to its start: a key-register write with the wrong value, a key write out of order, or any status-register write. A status write made before the full sequence leaves the guard state unchanged. Writes to other addresses do not disturb the sequence.
- R5: A completed sequence allows exactly one status write. A second status write needs the whole sequence again.
- R6: While the guard is on, a write is suppressed (`outWe` low) if its address is in 8'h00–8'h1F or 8'h40–8'h4F, or if it is a status write not preceded by a complete sequence.
- R7: Each suppressed write raises `violIrq` for exactly one cycle, in the cycle after the write.
- R8: `blockCount` rises by one for each suppressed write and holds at 255.
- R9: A write to any other address, excluding the key and status addresses, is forwarded in the same cycle with unchanged address and data, whatever the guard state. The key and status addresses are never forwarded.
- R10: `rdData` shows the guard state in bit 0, with all other bits 0, when `busAddr` is the status address. It is 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Bus address for writes and status reads |
| busWe | input | 1 | Single-cycle write strobe |
| busWdata | input | 8 | Bus write data |
| outAddr | output | 8 | Address forwarded to the register bank |
| outWe | output | 1 | Forwarded write strobe |
| outWdata | output | 8 | Data forwarded to the register bank |
| rdData | output | 8 | Status read data |
| protectOn | output | 1 | Current guard state |
| violIrq | output | 1 | One-cycle pulse per suppressed write |
| blockCount | output | 8 | Saturating count of suppressed writes |

## Verification
`outWe`, `outAddr`, `outWdata` and `rdData` are combinational, so the bench checks them 1 ns after driving the bus on the falling edge, before the write's rising edge. `protectOn`, `violIrq` and `blockCount` pass through one register. The bench checks them 1 ns after the rising edge that takes the write, against a model that it has already advanced for that write. Because every write is followed by this check, a pulse that lasts two cycles shows up when the next operation is checked.

// File: rtl/write_guard_pkg.sv
package write_guard_pkg;

  typedef enum logic [2:0] {
    KS_IDLE,
    KS_OPEN_A,
    KS_OPEN_DONE,
    KS_CLOSE_A,
    KS_ARMED
  } keyStateT;

  // decoded view of the current bus cycle, datapath -> control
  typedef struct packed {
    logic wr;
    logic hitKeyA;
    logic hitKeyB;
    logic hitStat;
    logic hitProt;
    logic valOpen;
    logic valClose;
    logic statBit;
  } decodeT;

  // strobes, control -> datapath
  typedef struct packed {
    logic block;
    logic protect;
  } strobeT;

endpackage

// File: rtl/write_guard_ctrl.sv
module write_guard_ctrl
  import write_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  decodeT dec,
  output strobeT strb
);

  keyStateT keyState, keyNext;
  logic     protectQ;
  logic     armed;

  assign armed = (keyState == KS_ARMED);

  always_comb begin
    keyNext = keyState;
    if (dec.wr) begin
      if (dec.hitKeyA) begin
        if (keyState == KS_IDLE && dec.valOpen)
          keyNext = KS_OPEN_A;
        else if (keyState == KS_OPEN_DONE && dec.valClose)
          keyNext = KS_CLOSE_A;
        else
          keyNext = KS_IDLE;
      end else if (dec.hitKeyB) begin
        if (keyState == KS_OPEN_A && dec.valClose)
          keyNext = KS_OPEN_DONE;
        else if (keyState == KS_CLOSE_A && dec.valOpen)
          keyNext = KS_ARMED;
        else
          keyNext = KS_IDLE;
      end else if (dec.hitStat) begin
        keyNext = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KS_IDLE;
      protectQ <= 1'b0;
    end else begin
      keyState <= keyNext;
      if (dec.wr && dec.hitStat && armed)
        protectQ <= dec.statBit;
    end
  end

  assign strb.protect = protectQ;
  assign strb.block   = dec.wr & protectQ & (dec.hitProt | (dec.hitStat & ~armed));

endmodule

// File: rtl/write_guard_dp.sv
module write_guard_dp
  import write_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NR = 2,
  parameter int CNT_W = 8,
  parameter logic [NR*AW-1:0] RANGE_LO = 16'h4000,
  parameter logic [NR*AW-1:0] RANGE_HI = 16'h4F1F,
  parameter logic [AW-1:0] STAT_ADDR = 8'hF0,
  parameter logic [AW-1:0] KEYA_ADDR = 8'hF1,
  parameter logic [AW-1:0] KEYB_ADDR = 8'hF2,
  parameter logic [DW-1:0] KEY_OPEN  = 8'h5A,
  parameter logic [DW-1:0] KEY_CLOSE = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWe,
  input  logic [DW-1:0]    busWdata,
  input  strobeT           strb,
  output decodeT           dec,
  output logic [AW-1:0]    outAddr,
  output logic             outWe,
  output logic [DW-1:0]    outWdata,
  output logic [DW-1:0]    rdData,
  output logic             violIrq,
  output logic [CNT_W-1:0] blockCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NR-1:0] rangeHit;
  logic          internal;

  for (genvar i = 0; i < NR; i++) begin : g_range
    assign rangeHit[i] = (busAddr >= RANGE_LO[i*AW +: AW]) &&
                         (busAddr <= RANGE_HI[i*AW +: AW]);
  end

  assign dec.wr       = busWe;
  assign dec.hitKeyA  = (busAddr == KEYA_ADDR);
  assign dec.hitKeyB  = (busAddr == KEYB_ADDR);
  assign dec.hitStat  = (busAddr == STAT_ADDR);
  assign dec.hitProt  = |rangeHit;
  assign dec.valOpen  = (busWdata == KEY_OPEN);
  assign dec.valClose = (busWdata == KEY_CLOSE);
  assign dec.statBit  = busWdata[0];

  assign internal = dec.hitKeyA | dec.hitKeyB | dec.hitStat;

  assign outAddr  = busAddr;
  assign outWdata = busWdata;
  assign outWe    = busWe & ~internal & ~strb.block;
  assign rdData   = dec.hitStat ? {{(DW-1){1'b0}}, strb.protect} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violIrq    <= 1'b0;
      blockCount <= '0;
    end else begin
      violIrq <= strb.block;
      if (strb.block && blockCount != CNT_MAX)
        blockCount <= blockCount + 1'b1;
    end
  end

endmodule

// File: rtl/write_guard.sv
module write_guard
  import write_guard_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NR = 2,
  parameter int CNT_W = 8,
  parameter logic [NR*AW-1:0] RANGE_LO = 16'h4000,
  parameter logic [NR*AW-1:0] RANGE_HI = 16'h4F1F,
  parameter logic [AW-1:0] STAT_ADDR = 8'hF0,
  parameter logic [AW-1:0] KEYA_ADDR = 8'hF1,
  parameter logic [AW-1:0] KEYB_ADDR = 8'hF2,
  parameter logic [DW-1:0] KEY_OPEN  = 8'h5A,
  parameter logic [DW-1:0] KEY_CLOSE = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWe,
  input  logic [DW-1:0]    busWdata,
  output logic [AW-1:0]    outAddr,
  output logic             outWe,
  output logic [DW-1:0]    outWdata,
  output logic [DW-1:0]    rdData,
  output logic             protectOn,
  output logic             violIrq,
  output logic [CNT_W-1:0] blockCount
);

  decodeT dec;
  strobeT strb;

  write_guard_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .dec  (dec),
    .strb (strb)
  );

  write_guard_dp #(
    .AW(AW), .DW(DW), .NR(NR), .CNT_W(CNT_W),
    .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI),
    .STAT_ADDR(STAT_ADDR), .KEYA_ADDR(KEYA_ADDR), .KEYB_ADDR(KEYB_ADDR),
    .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busWdata   (busWdata),
    .strb       (strb),
    .dec        (dec),
    .outAddr    (outAddr),
    .outWe      (outWe),
    .outWdata   (outWdata),
    .rdData     (rdData),
    .violIrq    (violIrq),
    .blockCount (blockCount)
  );

  assign protectOn = strb.protect;

endmodule

// File: rtl/write_guard_chk.sv
module write_guard_chk #(
  parameter int AW = 8,
  parameter int NR = 2,
  parameter int CNT_W = 8,
  parameter logic [NR*AW-1:0] RANGE_LO = 16'h4000,
  parameter logic [NR*AW-1:0] RANGE_HI = 16'h4F1F,
  parameter logic [AW-1:0] STAT_ADDR = 8'hF0
) (
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    busAddr,
  input logic             busWe,
  input logic [AW-1:0]    outAddr,
  input logic             outWe,
  input logic             protectOn,
  input logic             violIrq,
  input logic [CNT_W-1:0] blockCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic inRanges(input logic [AW-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NR; i++)
      if (a >= RANGE_LO[i*AW +: AW] && a <= RANGE_HI[i*AW +: AW]) hit = 1'b1;
    return hit;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!protectOn && !violIrq && blockCount == '0));

  a_r3_change_by_status: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protectOn) |-> ($past(busWe) && $past(busAddr) == STAT_ADDR));

  a_r6_range_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && protectOn && inRanges(busAddr)) |-> !outWe);

  a_r7_pulse_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && protectOn && inRanges(busAddr)) |=> violIrq);

  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    violIrq |-> ($past(busWe) && $past(protectOn) && !$past(outWe)));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (violIrq && $past(blockCount) != CNT_MAX) |-> blockCount == $past(blockCount) + 1'b1);

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !violIrq |-> $stable(blockCount));

  a_r9_forward_match: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> (busWe && outAddr == busAddr));

endmodule

bind write_guard write_guard_chk #(
  .AW(AW), .NR(NR), .CNT_W(CNT_W),
  .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .outAddr    (outAddr),
  .outWe      (outWe),
  .protectOn  (protectOn),
  .violIrq    (violIrq),
  .blockCount (blockCount)
);

// File: tb/write_guard_bench.sv
module write_guard_bench;

  localparam logic [7:0] STAT = 8'hF0, KA = 8'hF1, KB = 8'hF2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] outAddr, outWdata, rdData, blockCount;
  logic outWe, protectOn, violIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit mProt = 0;
  int mSeq = 0;
  int mCnt = 0;
  bit mIrq = 0;

  always #4 clk = ~clk;

  write_guard u_write_guard (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .outAddr(outAddr), .outWe(outWe), .outWdata(outWdata), .rdData(rdData),
    .protectOn(protectOn), .violIrq(violIrq), .blockCount(blockCount)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit inProt(input logic [7:0] a);
    return (a <= 8'h1F) || (a >= 8'h40 && a <= 8'h4F);
  endfunction

  function automatic bit isInternal(input logic [7:0] a);
    return a == STAT || a == KA || a == KB;
  endfunction

  task automatic checkRegs();
    check(protectOn == mProt, "R3 protectOn", protectOn, mProt);
    check(violIrq == mIrq, "R7 violIrq", violIrq, mIrq);
    check(blockCount == mCnt[7:0], "R8 blockCount", blockCount, mCnt);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    bit blk, expWe;
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    #1;
    blk = mProt && (inProt(a) || (a == STAT && mSeq != 4));
    expWe = !blk && !isInternal(a);
    if (inProt(a)) check(outWe == expWe, "R6 outWe", outWe, expWe);
    else check(outWe == expWe, "R9 outWe", outWe, expWe);
    if (expWe) check(outAddr == a && outWdata == d, "R9 forwarded", {outAddr, outWdata}, {a, d});
    // advance model
    if (a == KA) mSeq = (mSeq == 0 && d == 8'h5A) ? 1 : (mSeq == 2 && d == 8'hA5) ? 3 : 0;
    else if (a == KB) mSeq = (mSeq == 1 && d == 8'hA5) ? 2 : (mSeq == 3 && d == 8'h5A) ? 4 : 0;
    else if (a == STAT) begin
      if (mSeq == 4) mProt = d[0];
      mSeq = 0;
    end
    mIrq = blk;
    if (blk && mCnt < 255) mCnt++;
    @(posedge clk);
    #1;
    checkRegs();
  endtask

  task automatic idle();
    @(negedge clk);
    busWe = 1'b0;
    mIrq = 0;
    @(posedge clk);
    #1;
    checkRegs();
  endtask

  task automatic setProt(input bit v);
    doWrite(KA, 8'h5A); doWrite(KB, 8'hA5);
    doWrite(KA, 8'hA5); doWrite(KB, 8'h5A);
    doWrite(STAT, {7'd0, v});
  endtask

  task automatic readStat();
    @(negedge clk);
    busWe = 1'b0; busAddr = STAT;
    #1;
    check(rdData == {7'd0, mProt}, "R10 status read", rdData, mProt);
    busAddr = 8'h60;
    #1;
    check(rdData == 8'h00, "R10 other read", rdData, 0);
    mIrq = 0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] a, d;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    check(protectOn == 0 && violIrq == 0 && blockCount == 0, "R1 reset state",
          {protectOn, violIrq, blockCount}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(protectOn == 0 && violIrq == 0 && blockCount == 0, "R1 after release",
          {protectOn, violIrq, blockCount}, 0);

    // R9 pass-through while off, including protected ranges
    doWrite(8'h05, 8'h11); doWrite(8'h60, 8'h22); doWrite(8'h45, 8'h33);
    // R2/R3 set protection
    setProt(1);
    readStat();
    doWrite(8'h10, 8'h44);   // R6 blocked, R7 pulse
    doWrite(8'h60, 8'h55);   // R9 passes, pulse drops
    doWrite(8'h4F, 8'h01);   // R6 range edge
    doWrite(8'h20, 8'h01);   // R9 just past range
    // R4 wrong value and wrong order
    doWrite(KA, 8'h5A); doWrite(KB, 8'h5B); doWrite(KA, 8'hA5); doWrite(KB, 8'h5A);
    doWrite(STAT, 8'h00);    // R4 no change, R6 blocked status
    doWrite(KB, 8'hA5); doWrite(KA, 8'h5A); doWrite(STAT, 8'h00);
    // R4 unrelated writes between keys do not break it
    doWrite(KA, 8'h5A); doWrite(8'h70, 8'h01); doWrite(KB, 8'hA5);
    doWrite(KA, 8'hA5); doWrite(8'h00, 8'h01); doWrite(KB, 8'h5A);
    doWrite(STAT, 8'h00);    // clears protection
    readStat();
    // R5 one status write per sequence
    setProt(1);
    doWrite(STAT, 8'h00);    // blocked, stays on
    readStat();
    idle();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: a = KA;
        2, 3: a = KB;
        4: a = STAT;
        5, 6: a = inProt(8'($urandom)) ? 8'($urandom_range(0, 31)) : 8'($urandom_range(64, 79));
        default: a = 8'($urandom);
      endcase
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (($urandom_range(0, 1) == 1) ? 8'h5A : 8'hA5);
      if (a == STAT) d = 8'($urandom);
      if ($urandom_range(0, 99) == 0) setProt(1'($urandom));
      else if ($urandom_range(0, 9) == 0) idle();
      else doWrite(a, d);
    end

    // R8 saturation
    setProt(1);
    for (int i = 0; i < 270; i++) doWrite(8'h1F, 8'($urandom));
    check(blockCount == 8'd255, "R8 saturated", blockCount, 255);
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule